// File: doc/BRIEF.md
# Commutative-Update Reduction Line Unit

This block holds one shared cache line for several cores. While the line carries an operator label, each core keeps its own partial copy. That lets every core apply commutative updates (add, unsigned minimum or bitwise OR) to its copy in the same cycle as the others, and no core ever waits on another.

A core joins an already labeled line with a copy set to the operator's identity value. The earlier holders keep the real value. An ordinary load, or a labeled request with a different operator, starts a combining pass. The pass walks the partial copies one per cycle and merges them element by element into one line. The requester receives its element from that line and becomes the only holder of the merged line. The line then takes the new operator label, or no label after an ordinary load.

The unit does not combine inside a labeled store. A store replaces the element with the supplied value, so the core must first load the element, apply the operator, and then store the result.

Top module: `comm_line_unit`

## Requirements
- R1: After reset the line has no label (code 0), core 0 alone holds it, and every element is zero. All req_ready bits are high and no resp_valid bit is set.
- R2: A labeled request whose label equals the line's label is served from the requester's own copy, with the response one cycle after acceptance. A load returns the element and a store (req_wr=1) writes the element and echoes the data. Any number of cores can be accepted in the same cycle.
- R3: The first labeled access by a core that holds no copy starts that copy at the identity value: 0 for add (code 1) and OR (code 3), all ones for minimum (code 2).
- R4: A request with label code 0 starts a combining pass that takes one cycle per core copy. Its response comes NCORE cycles after acceptance and carries the merged element.
- R5: A labeled request whose label differs from the line's label also starts a combining pass. Afterwards the line carries the new label and the requester's copy holds the merged line, with the request applied to it.
- R6: During a combining pass every req_ready bit is low. After the pass only the requester holds a copy, so any other core that makes a labeled access starts again from the identity value.
- R7: When a cycle has no pass running and some valid request needs a pass, only the lowest-numbered such core sees req_ready high. With no such request, every core is ready.
- R8: The line starts at 20 and two cores each add 1 twice, leaving partial copies of 22 and 2. An ordinary load of that element then returns 24.
- R9: The pass merges copies with add, unsigned minimum or bitwise OR, according to the label the line had while the copies were updated.
- R10: The pass works on every element of the line separately. Elements that no core touched come out unchanged.
- R11: A request with label code 0 never writes, whatever the value of req_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Request valid, one bit per core |
| req_wr | input | NCORE | Per core: 1 = labeled store, 0 = load |
| req_lbl | input | 2*NCORE | Per core label: 0 none, 1 add, 2 min, 3 OR |
| req_idx | input | IDX_W*NCORE | Per core element index |
| req_data | input | ELEM_W*NCORE | Per core store data |
| req_ready | output | NCORE | Request accepted when valid and ready |
| resp_valid | output | NCORE | One-cycle response strobe per core |
| resp_data | output | ELEM_W*NCORE | Per core response element |

## Verification
A local hit is due on the clock edge right after acceptance. A request that starts a combining pass answers NCORE edges after its acceptance, and req_ready stays low for all the edges in between. The bench carries a behavioural model that steps once per clock. The model predicts req_ready for the inputs now being driven, and it predicts resp_valid and resp_data for the edge that is coming. Both predictions are compared on the falling edge, so each result is checked in exactly the cycle it falls due.

// File: rtl/clu_pkg.sv
package clu_pkg;
  typedef enum logic [1:0] {
    LBL_NONE = 2'd0,
    LBL_ADD  = 2'd1,
    LBL_MIN  = 2'd2,
    LBL_OR   = 2'd3
  } clu_lbl_e;
endpackage

// File: rtl/clu_line_comb.sv
// Element-wise merge of one partial copy into the running accumulator.
module clu_line_comb import clu_pkg::*; #(
  parameter int ELEM_W = 32,
  parameter int NELEM  = 8,
  localparam int LINE_W = ELEM_W * NELEM
) (
  input  clu_lbl_e          lbl,
  input  logic [LINE_W-1:0] acc_line,
  input  logic [LINE_W-1:0] copy_line,
  input  logic              copy_en,
  output logic [LINE_W-1:0] out_line
);
  for (genvar e = 0; e < NELEM; e++) begin : g_el
    logic [ELEM_W-1:0] a, b, r;
    assign a = acc_line[e*ELEM_W +: ELEM_W];
    assign b = copy_line[e*ELEM_W +: ELEM_W];
    always_comb begin
      case (lbl)
        LBL_ADD: r = a + b;
        LBL_MIN: r = (b < a) ? b : a;
        default: r = a | b;   // OR; an unlabeled line has one holder over zero
      endcase
    end
    assign out_line[e*ELEM_W +: ELEM_W] = copy_en ? r : a;
  end
endmodule

// File: rtl/clu_req_arb.sv
// Grants all cores for local hits, or the lowest core needing a merge pass.
module clu_req_arb #(
  parameter int NCORE = 4,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic              idle,
  input  logic [NCORE-1:0]  need,
  output logic [NCORE-1:0]  ready,
  output logic              red_go,
  output logic [CORE_W-1:0] red_idx
);
  always_comb begin
    red_idx = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (need[i]) red_idx = CORE_W'(i);
    end
    red_go = idle && (need != '0);
    if (!idle)            ready = '0;
    else if (need != '0)  ready = NCORE'(1) << red_idx;
    else                  ready = '1;
  end
endmodule

// File: rtl/comm_line_unit.sv
module comm_line_unit import clu_pkg::*; #(
  parameter int NCORE  = 4,
  parameter int NELEM  = 8,
  parameter int ELEM_W = 32,
  localparam int IDX_W  = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int LINE_W = NELEM * ELEM_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCORE-1:0]        req_valid,
  input  logic [NCORE-1:0]        req_wr,
  input  logic [2*NCORE-1:0]      req_lbl,
  input  logic [IDX_W*NCORE-1:0]  req_idx,
  input  logic [ELEM_W*NCORE-1:0] req_data,
  output logic [NCORE-1:0]        req_ready,
  output logic [NCORE-1:0]        resp_valid,
  output logic [ELEM_W*NCORE-1:0] resp_data
);
  logic [LINE_W-1:0] copy_q [NCORE];
  logic [ELEM_W-1:0] resp_q [NCORE];
  logic [NCORE-1:0]  hold_q;
  clu_lbl_e          lbl_q;
  logic              busy_q;
  logic [CORE_W-1:0] step_q;
  logic [LINE_W-1:0] acc_q;
  logic [CORE_W-1:0] rq_core;
  clu_lbl_e          rq_lbl;
  logic              rq_wr;
  logic [IDX_W-1:0]  rq_idx;
  logic [ELEM_W-1:0] rq_data;

  function automatic logic [LINE_W-1:0] ident_line(clu_lbl_e l);
    return (l == LBL_MIN) ? {LINE_W{1'b1}} : {LINE_W{1'b0}};
  endfunction

  // ---- request decode ----
  clu_lbl_e          c_lbl [NCORE];
  logic [IDX_W-1:0]  c_idx [NCORE];
  logic [ELEM_W-1:0] c_dat [NCORE];
  logic [NCORE-1:0]  need;
  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      c_lbl[c] = clu_lbl_e'(req_lbl[2*c +: 2]);
      c_idx[c] = req_idx[IDX_W*c +: IDX_W];
      c_dat[c] = req_data[ELEM_W*c +: ELEM_W];
      need[c]  = req_valid[c] && (c_lbl[c] == LBL_NONE || c_lbl[c] != lbl_q);
    end
  end

  logic              red_go;
  logic [CORE_W-1:0] red_idx;
  clu_req_arb #(.NCORE(NCORE)) u_arb (
    .idle(!busy_q), .need(need), .ready(req_ready),
    .red_go(red_go), .red_idx(red_idx)
  );

  // ---- local hit path ----
  logic [LINE_W-1:0] hit_line [NCORE];
  logic [ELEM_W-1:0] hit_resp [NCORE];
  logic [NCORE-1:0]  hit_acc;
  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      hit_acc[c]  = req_valid[c] && req_ready[c] && !need[c];
      hit_line[c] = hold_q[c] ? copy_q[c] : ident_line(lbl_q);
      hit_resp[c] = req_wr[c] ? c_dat[c] : hit_line[c][c_idx[c]*ELEM_W +: ELEM_W];
      if (req_wr[c]) hit_line[c][c_idx[c]*ELEM_W +: ELEM_W] = c_dat[c];
    end
  end

  // ---- merge pass, one copy per cycle ----
  logic [LINE_W-1:0] comb_line;
  clu_line_comb #(.ELEM_W(ELEM_W), .NELEM(NELEM)) u_comb (
    .lbl(lbl_q), .acc_line(acc_q), .copy_line(copy_q[step_q]),
    .copy_en(hold_q[step_q]), .out_line(comb_line)
  );

  logic              last_step;
  logic [LINE_W-1:0] fin_line;
  logic [ELEM_W-1:0] fin_resp;
  assign last_step = busy_q && (step_q == CORE_W'(NCORE - 1));
  always_comb begin
    fin_line = comb_line;
    fin_resp = comb_line[rq_idx*ELEM_W +: ELEM_W];
    if (rq_lbl != LBL_NONE && rq_wr) begin
      fin_line[rq_idx*ELEM_W +: ELEM_W] = rq_data;
      fin_resp = rq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lbl_q      <= LBL_NONE;
      hold_q     <= NCORE'(1);
      busy_q     <= 1'b0;
      step_q     <= '0;
      acc_q      <= '0;
      rq_core    <= '0;
      rq_lbl     <= LBL_NONE;
      rq_wr      <= 1'b0;
      rq_idx     <= '0;
      rq_data    <= '0;
      resp_valid <= '0;
      for (int c = 0; c < NCORE; c++) begin
        copy_q[c] <= '0;
        resp_q[c] <= '0;
      end
    end else begin
      resp_valid <= '0;
      if (busy_q) begin
        acc_q  <= comb_line;
        step_q <= step_q + 1'b1;
        if (last_step) begin
          busy_q              <= 1'b0;
          step_q              <= '0;
          copy_q[rq_core]     <= fin_line;
          hold_q              <= NCORE'(1) << rq_core;
          lbl_q               <= rq_lbl;
          resp_valid[rq_core] <= 1'b1;
          resp_q[rq_core]     <= fin_resp;
        end
      end else begin
        for (int c = 0; c < NCORE; c++) begin
          if (hit_acc[c]) begin
            copy_q[c]     <= hit_line[c];
            hold_q[c]     <= 1'b1;
            resp_valid[c] <= 1'b1;
            resp_q[c]     <= hit_resp[c];
          end
        end
        if (red_go) begin
          busy_q  <= 1'b1;
          step_q  <= '0;
          acc_q   <= ident_line(lbl_q);
          rq_core <= red_idx;
          rq_lbl  <= c_lbl[red_idx];
          rq_wr   <= req_wr[red_idx];
          rq_idx  <= c_idx[red_idx];
          rq_data <= c_dat[red_idx];
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCORE; c++) resp_data[ELEM_W*c +: ELEM_W] = resp_q[c];
  end

  // ---- assertions ----
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && hit_acc != '0) |=> (resp_valid == $past(hit_acc))); // R2
  AST_MERGE_RESP: assert property (@(posedge clk) disable iff (rst)
    last_step |=> (resp_valid == (NCORE'(1) << $past(rq_core)))); // R4
  AST_LABEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_step) |=> $stable(lbl_q)); // R5
  AST_STALL_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (req_ready == '0)); // R6
  AST_SOLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(busy_q)) |-> ($countones(hold_q) == 1)); // R6
  AST_ONE_MERGER: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && need != '0) |-> $onehot(req_ready)); // R7
endmodule

// File: tb/comm_line_unit_bench.sv
module comm_line_unit_bench;
  localparam int NC = 4, NE = 8, EW = 32, IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [NC-1:0]    req_valid, req_wr, req_ready, resp_valid;
  logic [2*NC-1:0]  req_lbl;
  logic [IW*NC-1:0] req_idx;
  logic [EW*NC-1:0] req_data, resp_data;

  logic        b_vld [NC];
  logic        b_wr  [NC];
  int          b_lbl [NC];
  int          b_idx [NC];
  logic [31:0] b_dat [NC];

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      req_valid[c]            = b_vld[c];
      req_wr[c]               = b_wr[c];
      req_lbl[2*c +: 2]       = b_lbl[c][1:0];
      req_idx[IW*c +: IW]     = b_idx[c][IW-1:0];
      req_data[EW*c +: EW]    = b_dat[c];
    end
  end

  comm_line_unit u_comm_line_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
    .req_lbl(req_lbl), .req_idx(req_idx), .req_data(req_data),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data)
  );

  // ---- behavioural reference ----
  logic [31:0] m_copy [NC][NE];
  bit          m_hold [NC];
  int          m_lbl, m_rem, m_rc, r_lbl, r_idx;
  bit          r_wr;
  logic [31:0] r_dat;
  bit          acc   [NC];
  logic [31:0] last_rsp [NC];

  int    nchk = 0, nfail = 0, cycles = 0;
  string tag = "R1";

  function automatic logic [31:0] ident(int l);
    return (l == 2) ? 32'hFFFF_FFFF : 32'h0;
  endfunction
  function automatic logic [31:0] merge(int l, logic [31:0] a, logic [31:0] b);
    if (l == 1) return a + b;
    if (l == 2) return (b < a) ? b : a;
    return a | b;
  endfunction

  task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic tick();
    bit          need [NC];
    bit          any_need;
    int          low;
    logic [NC-1:0] er, erv;
    logic [31:0] erd [NC];
    logic [31:0] red [NE];
    #1;
    any_need = 0; low = -1;
    for (int c = 0; c < NC; c++) begin
      need[c] = b_vld[c] && (b_lbl[c] == 0 || b_lbl[c] != m_lbl);
      if (need[c] && low < 0) low = c;
      if (need[c]) any_need = 1;
    end
    for (int c = 0; c < NC; c++)
      er[c] = (m_rem > 0) ? 1'b0 : (any_need ? (c == low) : 1'b1);
    chk(req_ready === er, (m_rem > 0) ? "R6 ready" : "R7 ready", 32'(req_ready), 32'(er));
    erv = '0;
    for (int c = 0; c < NC; c++) begin
      acc[c] = b_vld[c] && er[c];
      erd[c] = '0;
    end
    if (m_rem > 0) begin
      m_rem--;
      if (m_rem == 0) begin
        for (int e = 0; e < NE; e++) begin
          red[e] = ident(m_lbl);
          for (int k = 0; k < NC; k++)
            if (m_hold[k]) red[e] = merge(m_lbl, red[e], m_copy[k][e]);
        end
        for (int k = 0; k < NC; k++) m_hold[k] = (k == m_rc);
        for (int e = 0; e < NE; e++) m_copy[m_rc][e] = red[e];
        m_lbl = r_lbl;
        erd[m_rc] = red[r_idx];
        if (r_lbl != 0 && r_wr) begin
          m_copy[m_rc][r_idx] = r_dat;
          erd[m_rc] = r_dat;
        end
        erv[m_rc] = 1'b1;
      end
    end else if (any_need) begin
      m_rem = NC; m_rc = low;
      r_lbl = b_lbl[low]; r_wr = b_wr[low]; r_idx = b_idx[low]; r_dat = b_dat[low];
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (acc[c]) begin
          if (!m_hold[c]) begin
            for (int e = 0; e < NE; e++) m_copy[c][e] = ident(m_lbl);
            m_hold[c] = 1;
          end
          if (b_wr[c]) begin
            m_copy[c][b_idx[c]] = b_dat[c];
            erd[c] = b_dat[c];
          end else erd[c] = m_copy[c][b_idx[c]];
          erv[c] = 1'b1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(resp_valid === erv, {tag, " resp_valid"}, 32'(resp_valid), 32'(erv));
    for (int c = 0; c < NC; c++) begin
      if (erv[c]) begin
        last_rsp[c] = resp_data[EW*c +: EW];
        chk(last_rsp[c] === erd[c], {tag, " resp_data"}, last_rsp[c], erd[c]);
      end
    end
  endtask

  task automatic post(int c, int l, bit w, int i, logic [31:0] d);
    b_vld[c] = 1; b_lbl[c] = l; b_wr[c] = w; b_idx[c] = i; b_dat[c] = d;
  endtask

  task automatic run();
    bit busy;
    do begin
      tick();
      busy = (m_rem > 0);
      for (int c = 0; c < NC; c++) begin
        if (acc[c]) b_vld[c] = 0;
        if (b_vld[c]) busy = 1;
      end
    end while (busy);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      b_vld[c] = 0; b_wr[c] = 0; b_lbl[c] = 0; b_idx[c] = 0; b_dat[c] = '0;
      m_hold[c] = (c == 0);
      for (int e = 0; e < NE; e++) m_copy[c][e] = '0;
    end
    m_lbl = 0; m_rem = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: idle after reset, line all zero
    tag = "R1";
    tick();
    chk(req_ready === 4'hF, "R1 ready after reset", 32'(req_ready), 32'hF);
    post(3, 0, 0, 4, 32'h0); run();
    chk(last_rsp[3] === 32'h0, "R1 initial element", last_rsp[3], 32'h0);

    // R8: worked add case, concurrent local updates (R2), identity join (R3)
    tag = "R8";
    post(0, 1, 0, 0, 32'h0); run();
    post(0, 1, 1, 0, 32'd20); run();
    post(1, 1, 0, 0, 32'h0); run();
    chk(last_rsp[1] === 32'h0, "R3 add identity", last_rsp[1], 32'h0);
    tag = "R2";
    post(0, 1, 1, 0, 32'd21); post(1, 1, 1, 0, 32'd1); run();
    post(0, 1, 1, 0, 32'd22); post(1, 1, 1, 0, 32'd2); run();
    post(0, 1, 0, 0, 32'h0); post(1, 1, 0, 0, 32'h0); run();
    chk(last_rsp[0] === 32'd22, "R2 partial core0", last_rsp[0], 32'd22);
    chk(last_rsp[1] === 32'd2, "R2 partial core1", last_rsp[1], 32'd2);
    tag = "R4";
    post(2, 0, 0, 0, 32'h0); run();
    chk(last_rsp[2] === 32'd24, "R8 merged sum", last_rsp[2], 32'd24);

    // R5/R9: relabel to min, unsigned compare
    tag = "R5";
    post(3, 2, 1, 2, 32'd50); run();
    chk(last_rsp[3] === 32'd50, "R5 relabel store", last_rsp[3], 32'd50);
    post(0, 2, 0, 2, 32'h0); run();
    chk(last_rsp[0] === 32'hFFFF_FFFF, "R3 min identity", last_rsp[0], 32'hFFFF_FFFF);
    tag = "R9";
    post(0, 2, 1, 2, 32'd7); post(1, 2, 1, 2, 32'h9000_0000); run();
    post(2, 0, 0, 2, 32'h0); run();
    chk(last_rsp[2] === 32'd7, "R9 unsigned min", last_rsp[2], 32'd7);
    tag = "R10";
    post(0, 0, 0, 0, 32'h0); run();
    chk(last_rsp[0] === 32'd24, "R10 untouched element", last_rsp[0], 32'd24);

    // R7: two cores relabel in one cycle; lowest goes first
    tag = "R7";
    post(1, 3, 1, 5, 32'h0F0); post(2, 3, 1, 5, 32'hF00);
    #1;
    chk(req_ready === 4'b0010, "R7 lowest merger only", 32'(req_ready), 32'h2);
    run();
    tag = "R9";
    post(0, 0, 0, 5, 32'h0); run();
    chk(last_rsp[0] === 32'hFF0, "R9 OR merge", last_rsp[0], 32'hFF0);

    // R11: unlabeled request with write set writes nothing
    tag = "R11";
    post(3, 0, 1, 5, 32'hDEAD); run();
    chk(last_rsp[3] === 32'hFF0, "R11 no write response", last_rsp[3], 32'hFF0);
    post(3, 0, 0, 5, 32'h0); run();
    chk(last_rsp[3] === 32'hFF0, "R11 element unchanged", last_rsp[3], 32'hFF0);

    // R6/R2: all four cores update one element together after a pass
    tag = "R6";
    post(0, 1, 0, 0, 32'h0); run();
    post(0, 1, 1, 1, 32'd1); post(1, 1, 1, 1, 32'd2);
    post(2, 1, 1, 1, 32'd3); post(3, 1, 1, 1, 32'd4);
    #1;
    chk(req_ready === 4'hF, "R2 all cores ready", 32'(req_ready), 32'hF);
    run();
    post(1, 0, 0, 1, 32'h0); run();
    chk(last_rsp[1] === 32'd10, "R6 identity rejoin sum", last_rsp[1], 32'd10);
    post(2, 0, 0, 0, 32'h0); run();
    chk(last_rsp[2] === 32'd24, "R10 element 0 kept", last_rsp[2], 32'd24);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule